// File: doc/BRIEF.md
# Three-Wire Codec Control Write Master

This block turns one control write from a host into the serial waveform that an audio codec expects on its three-wire control port. The port has a serial clock, a serial data line and a select line. The select line tells the codec whether the byte being shifted is the device address or register data. The host presents a 6-bit device address, a 2-bit register kind, one or two data bytes and a flag that asks for the second byte. It then pulses `start` for one cycle. The block engages the lines, sends the address byte and then the data bytes. Afterwards it drives all lines high for one cycle, releases them and pulses `done`.

Every phase duration is a parameter counted in system clock cycles: clock low, clock high, setup before a byte, hold after a byte, and the halt gap that separates consecutive data bytes. A direct register write carries one data byte. An extended register write carries two (extended address, then value) behind a single address byte. An option chooses whether the pins come from a flop stage or straight from the decoder.

Top module: `ctl3w_write_master`

## Requirements
- R1: A synchronous reset, including one that arrives in the middle of a transfer, leaves `wire_oe`, `busy` and `done` low from the first sample after the reset edge, and the block then accepts a new transfer.
- R2: A `start` seen while idle is accepted. On the first sample after that edge `wire_oe` and `busy` are still low. From the second sample the three lines are driven with clock, data and select all high for T_SETUP cycles, and `busy` is high.
- R3: The address byte is sent first. Its bits 7:2 are `dev_addr` and its bits 1:0 are `reg_kind`. Every byte goes out least significant bit first, 8 bits per byte.
- R4: Each bit cell is clock low for T_LOW cycles followed by clock high for T_HIGH cycles. The data line carries the bit value for the whole cell.
- R5: The address byte is preceded by clock low for T_SETUP cycles, and its last bit is followed by clock high for T_HOLD cycles.
- R6: The select line is low throughout the address byte, including its setup and hold, and high throughout all data-byte phases.
- R7: The first data byte follows the address hold with T_SETUP cycles of clock high, then its 8 bits, then T_HOLD cycles of clock high. When `ext_write`=1, a second data byte follows. It is preceded by clock low for T_HALT cycles, then clock high for T_HIGH, then T_SETUP cycles of clock high. When `ext_write`=0 there is no such gap and no second byte.
- R8: Outside the bit cells, the data line keeps the value of the last bit sent, or 1 before the first bit of a transfer.
- R9: After the final hold the lines stay driven high for one cycle. On the next sample `wire_oe` is low, `busy` is low and `done` is high for exactly one cycle.
- R10: A `start` pulse during a transfer is ignored. The running transfer keeps its captured address and data, and no second transfer follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request to begin a write |
| dev_addr | input | 6 | Codec device address, upper part of the address byte |
| reg_kind | input | 2 | Register kind code, lower part of the address byte |
| ext_write | input | 1 | 1 sends two data bytes, 0 sends one |
| byte_a | input | 8 | First data byte |
| byte_b | input | 8 | Second data byte (extended writes only) |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle pulse as the lines are released |
| wire_oe | output | 1 | Output enable for the three control lines |
| wire_clk | output | 1 | Serial clock line value |
| wire_dat | output | 1 | Serial data line value |
| wire_sel | output | 1 | Select line value (low for address, high for data) |

## Verification
The bench rebuilds the full expected pin waveform from the requirements and compares it cycle by cycle. A design that shifts MSB first, drops the halt gap, or inserts it before the first data byte breaks the byte decode or the clock comparison. A design that lets the data line drift outside the bit cells fails the data comparison. The bench fires a second `start` with different data halfway through an extended write. A design that re-captures its inputs would send corrupted bytes, and a design that queues the request would engage the lines again after `done`. A reset in mid-transfer must drop the enable at once, and the write that follows must still produce a clean waveform.

// File: rtl/ctl3w_pkg.sv
package ctl3w_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ENGAGE,
      ST_SETUP,
      ST_BIT_LO,
      ST_BIT_HI,
      ST_HOLD,
      ST_HALT_LO,
      ST_HALT_HI,
      ST_FINISH
   } ctl3w_state_e;

   // pin bundle handed from the decoder to the output stage
   typedef struct packed {
      logic oe;
      logic sclk;
      logic sdat;
      logic sel;
      logic done;
      logic busy;
   } ctl3w_pins_t;

   localparam ctl3w_pins_t PINS_RELEASED = '{oe: 1'b0, sclk: 1'b1, sdat: 1'b1,
                                             sel: 1'b1, done: 1'b0, busy: 1'b0};

   function automatic int max_of5(input int a, input int b, input int c,
                                  input int d, input int e);
      int m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      if (e > m) m = e;
      return m;
   endfunction

endpackage

// File: rtl/ctl3w_timer.sv
module ctl3w_timer #(
   parameter int CW = 4
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          zero
);
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);

   // an expired phase counter stays expired until the FSM reloads it
   p_timer_parked_r4: assert property (@(posedge clk) disable iff (rst)
      (zero && !load) |=> zero);

endmodule

// File: rtl/ctl3w_shifter.sv
module ctl3w_shifter #(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic [BYTE_W-1:0] load_byte,
   input  logic              shift,
   output logic              bit_o,
   output logic              last_o
);
   localparam int IW = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
   localparam logic [IW-1:0] LAST_IDX = IW'(BYTE_W - 1);

   logic [BYTE_W-1:0] sh_q;
   logic [IW-1:0]     idx_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         sh_q  <= '0;
         idx_q <= '0;
      end else if (load) begin
         sh_q  <= load_byte;
         idx_q <= '0;
      end else if (shift) begin
         sh_q  <= sh_q >> 1;
         idx_q <= idx_q + 1'b1;
      end
   end

   // least significant bit leaves first
   assign bit_o  = sh_q[0];
   assign last_o = (idx_q == LAST_IDX);

   p_no_shift_past_byte_r3: assert property (@(posedge clk) disable iff (rst)
      shift |-> !last_o);

endmodule

// File: rtl/ctl3w_pin_stage.sv
module ctl3w_pin_stage
   import ctl3w_pkg::*;
#(
   parameter bit REGISTER_PINS = 1'b1
) (
   input  logic        clk,
   input  logic        rst,
   input  ctl3w_pins_t pins_d,
   output ctl3w_pins_t pins_q
);
   generate
      if (REGISTER_PINS) begin : g_flopped
         ctl3w_pins_t q_r;
         always_ff @(posedge clk) begin
            if (rst)
               q_r <= PINS_RELEASED;
            else
               q_r <= pins_d;
         end
         assign pins_q = q_r;
      end else begin : g_direct
         logic unused_ok;
         assign unused_ok = clk ^ rst;
         assign pins_q = rst ? PINS_RELEASED : pins_d;
      end
   endgenerate

endmodule

// File: rtl/ctl3w_write_master.sv
module ctl3w_write_master
   import ctl3w_pkg::*;
#(
   parameter int ADDR_W        = 6,
   parameter int KIND_W        = 2,
   parameter int BYTE_W        = 8,
   parameter int T_LOW         = 4,
   parameter int T_HIGH        = 4,
   parameter int T_SETUP       = 2,
   parameter int T_HOLD        = 2,
   parameter int T_HALT        = 6,
   parameter bit REGISTER_PINS = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic [ADDR_W-1:0] dev_addr,
   input  logic [KIND_W-1:0] reg_kind,
   input  logic              ext_write,
   input  logic [BYTE_W-1:0] byte_a,
   input  logic [BYTE_W-1:0] byte_b,
   output logic              busy,
   output logic              done,
   output logic              wire_oe,
   output logic              wire_clk,
   output logic              wire_dat,
   output logic              wire_sel
);
   localparam int TMAX = max_of5(T_LOW, T_HIGH, T_SETUP, T_HOLD, T_HALT);
   localparam int CW   = (TMAX > 1) ? $clog2(TMAX) : 1;
   localparam logic [CW-1:0] LD_LOW   = CW'(T_LOW - 1);
   localparam logic [CW-1:0] LD_HIGH  = CW'(T_HIGH - 1);
   localparam logic [CW-1:0] LD_SETUP = CW'(T_SETUP - 1);
   localparam logic [CW-1:0] LD_HOLD  = CW'(T_HOLD - 1);
   localparam logic [CW-1:0] LD_HALT  = CW'(T_HALT - 1);

   // elaboration-time parameter checks
   generate
      if (T_LOW < 1 || T_HIGH < 1 || T_SETUP < 1 || T_HOLD < 1 || T_HALT < 1) begin : g_bad_timing
         $error("ctl3w_write_master: every phase length must be at least one cycle");
      end
      if (ADDR_W + KIND_W != BYTE_W) begin : g_bad_split
         $error("ctl3w_write_master: address and kind fields must fill one byte");
      end
   endgenerate

   // ---------------- state ----------------
   ctl3w_state_e      state_q, state_d;
   logic [1:0]        idx_q;
   logic              ext_q;
   logic [BYTE_W-1:0] addr_q, a_q, b_q;
   logic              hold_q;
   logic              done_q;

   // control strobes from the next-state logic
   logic              t_load, t_zero;
   logic [CW-1:0]     t_val;
   logic              sh_load, sh_shift, sh_bit, sh_last;
   logic              idx_inc, accept, done_set;
   logic [BYTE_W-1:0] cur_byte;

   // ---------------- phase counter ----------------
   ctl3w_timer #(.CW(CW)) u_timer (
      .clk      (clk),
      .rst      (rst),
      .load     (t_load),
      .load_val (t_val),
      .zero     (t_zero)
   );

   // ---------------- byte shifter ----------------
   always_comb begin
      unique case (idx_q)
         2'd0:    cur_byte = addr_q;
         2'd1:    cur_byte = a_q;
         default: cur_byte = b_q;
      endcase
   end

   ctl3w_shifter #(.BYTE_W(BYTE_W)) u_shift (
      .clk       (clk),
      .rst       (rst),
      .load      (sh_load),
      .load_byte (cur_byte),
      .shift     (sh_shift),
      .bit_o     (sh_bit),
      .last_o    (sh_last)
   );

   // ---------------- next-state logic ----------------
   always_comb begin
      state_d  = state_q;
      t_load   = 1'b0;
      t_val    = '0;
      sh_load  = 1'b0;
      sh_shift = 1'b0;
      idx_inc  = 1'b0;
      accept   = 1'b0;
      done_set = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (start) begin
               accept  = 1'b1;
               state_d = ST_ENGAGE;
               t_load  = 1'b1;
               t_val   = LD_SETUP;
            end
         end
         ST_ENGAGE: begin
            if (t_zero) begin
               state_d = ST_SETUP;
               t_load  = 1'b1;
               t_val   = LD_SETUP;
            end
         end
         ST_SETUP: begin
            sh_load = 1'b1;
            if (t_zero) begin
               state_d = ST_BIT_LO;
               t_load  = 1'b1;
               t_val   = LD_LOW;
            end
         end
         ST_BIT_LO: begin
            if (t_zero) begin
               state_d = ST_BIT_HI;
               t_load  = 1'b1;
               t_val   = LD_HIGH;
            end
         end
         ST_BIT_HI: begin
            if (t_zero) begin
               t_load = 1'b1;
               if (!sh_last) begin
                  sh_shift = 1'b1;
                  state_d  = ST_BIT_LO;
                  t_val    = LD_LOW;
               end else begin
                  state_d  = ST_HOLD;
                  t_val    = LD_HOLD;
               end
            end
         end
         ST_HOLD: begin
            if (t_zero) begin
               t_load = 1'b1;
               if (idx_q == 2'd0) begin
                  idx_inc = 1'b1;
                  state_d = ST_SETUP;
                  t_val   = LD_SETUP;
               end else if (idx_q == 2'd1 && ext_q) begin
                  idx_inc = 1'b1;
                  state_d = ST_HALT_LO;
                  t_val   = LD_HALT;
               end else begin
                  state_d = ST_FINISH;
                  t_val   = '0;
               end
            end
         end
         ST_HALT_LO: begin
            if (t_zero) begin
               state_d = ST_HALT_HI;
               t_load  = 1'b1;
               t_val   = LD_HIGH;
            end
         end
         ST_HALT_HI: begin
            if (t_zero) begin
               state_d = ST_SETUP;
               t_load  = 1'b1;
               t_val   = LD_SETUP;
            end
         end
         ST_FINISH: begin
            if (t_zero) begin
               state_d  = ST_IDLE;
               done_set = 1'b1;
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   // ---------------- registers ----------------
   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_IDLE;
         idx_q   <= 2'd0;
         ext_q   <= 1'b0;
         addr_q  <= '0;
         a_q     <= '0;
         b_q     <= '0;
         hold_q  <= 1'b1;
         done_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         done_q  <= done_set;
         if (accept) begin
            idx_q  <= 2'd0;
            ext_q  <= ext_write;
            addr_q <= {dev_addr, reg_kind};
            a_q    <= byte_a;
            b_q    <= byte_b;
            hold_q <= 1'b1;
         end else begin
            if (idx_inc)
               idx_q <= idx_q + 2'd1;
            if (state_q == ST_BIT_HI)
               hold_q <= sh_bit;
         end
      end
   end

   // ---------------- pin decode ----------------
   ctl3w_pins_t pins_d, pins_q;
   logic        in_data;

   assign in_data = (idx_q != 2'd0);

   always_comb begin
      pins_d      = PINS_RELEASED;
      pins_d.done = done_q;
      pins_d.busy = (state_q != ST_IDLE);
      unique case (state_q)
         ST_ENGAGE, ST_FINISH: begin
            pins_d.oe = 1'b1;
         end
         ST_SETUP: begin
            pins_d.oe   = 1'b1;
            pins_d.sclk = in_data;
            pins_d.sdat = hold_q;
            pins_d.sel  = in_data;
         end
         ST_BIT_LO, ST_BIT_HI: begin
            pins_d.oe   = 1'b1;
            pins_d.sclk = (state_q == ST_BIT_HI);
            pins_d.sdat = sh_bit;
            pins_d.sel  = in_data;
         end
         ST_HOLD: begin
            pins_d.oe   = 1'b1;
            pins_d.sdat = hold_q;
            pins_d.sel  = in_data;
         end
         ST_HALT_LO, ST_HALT_HI: begin
            pins_d.oe   = 1'b1;
            pins_d.sclk = (state_q == ST_HALT_HI);
            pins_d.sdat = hold_q;
         end
         default: ;
      endcase
   end

   ctl3w_pin_stage #(.REGISTER_PINS(REGISTER_PINS)) u_pins (
      .clk    (clk),
      .rst    (rst),
      .pins_d (pins_d),
      .pins_q (pins_q)
   );

   assign wire_oe  = pins_q.oe;
   assign wire_clk = pins_q.sclk;
   assign wire_dat = pins_q.sdat;
   assign wire_sel = pins_q.sel;
   assign busy     = pins_q.busy;
   assign done     = pins_q.done;

   // ---------------- assertions ----------------
   // data stays put across the rising clock inside a bit cell
   p_bit_data_steady_r4: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_BIT_HI && $past(state_q) == ST_BIT_LO) |-> (sh_bit == $past(sh_bit)));

   // a byte is closed only after its final bit
   p_hold_after_last_bit_r3: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_HOLD && $past(state_q) == ST_BIT_HI) |-> $past(sh_last));

   // the halt gap only ever precedes the second data byte of an extended write
   p_halt_second_only_r7: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_HALT_LO) |-> (idx_q == 2'd2 && ext_q));

   // captured transfer contents do not move when start arrives mid-transfer
   p_busy_start_ignored_r10: assert property (@(posedge clk) disable iff (rst)
      (state_q != ST_IDLE && start) |=> ($stable(addr_q) && $stable(a_q) &&
                                         $stable(b_q) && $stable(ext_q)));

   // done coincides with the release of the lines, and lasts one cycle
   p_done_released_r9: assert property (@(posedge clk) disable iff (rst)
      done |-> (!wire_oe && !busy));

   p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);

endmodule

// File: tb/ctl3w_write_master_bench.sv
module ctl3w_write_master_bench;

   localparam int TL  = 3;
   localparam int TH  = 2;
   localparam int TS  = 2;
   localparam int THD = 3;
   localparam int THT = 5;
   localparam int NCAP = 1024;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       start = 1'b0;
   logic [5:0] dev_addr = '0;
   logic [1:0] reg_kind = '0;
   logic       ext_write = 1'b0;
   logic [7:0] byte_a = '0;
   logic [7:0] byte_b = '0;
   logic       busy, done, wire_oe, wire_clk, wire_dat, wire_sel;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   ctl3w_write_master #(
      .T_LOW(TL), .T_HIGH(TH), .T_SETUP(TS), .T_HOLD(THD), .T_HALT(THT)
   ) u_ctl3w_write_master (
      .clk(clk), .rst(rst), .start(start), .dev_addr(dev_addr),
      .reg_kind(reg_kind), .ext_write(ext_write), .byte_a(byte_a),
      .byte_b(byte_b), .busy(busy), .done(done), .wire_oe(wire_oe),
      .wire_clk(wire_clk), .wire_dat(wire_dat), .wire_sel(wire_sel)
   );

   // expected waveform and captured samples
   logic e_clk [NCAP];
   logic e_dat [NCAP];
   logic e_sel [NCAP];
   int   e_len;
   logic c_oe [NCAP], c_clk [NCAP], c_dat [NCAP], c_sel [NCAP], c_done [NCAP], c_busy [NCAP];

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic push(input int n, input logic c, input logic d, input logic s);
      for (int k = 0; k < n; k++) begin
         e_clk[e_len] = c;
         e_dat[e_len] = d;
         e_sel[e_len] = s;
         e_len++;
      end
   endtask

   task automatic push_byte(input logic [7:0] v, input logic s);
      for (int k = 0; k < 8; k++) begin
         push(TL, 1'b0, v[k], s);
         push(TH, 1'b1, v[k], s);
      end
      push(THD, 1'b1, v[7], s);
   endtask

   task automatic build_expected(input logic [5:0] dv, input logic [1:0] kd,
                                 input logic ex, input logic [7:0] a, input logic [7:0] b);
      logic [7:0] ab;
      ab = {dv, kd};
      e_len = 0;
      push(TS, 1'b1, 1'b1, 1'b1);          // engage, all high
      push(TS, 1'b0, 1'b1, 1'b0);          // address setup, clock low
      push_byte(ab, 1'b0);
      push(TS, 1'b1, ab[7], 1'b1);         // first data setup
      push_byte(a, 1'b1);
      if (ex) begin
         push(THT, 1'b0, a[7], 1'b1);      // halt gap
         push(TH, 1'b1, a[7], 1'b1);
         push(TS, 1'b1, a[7], 1'b1);
         push_byte(b, 1'b1);
      end
      push(1, 1'b1, 1'b1, 1'b1);           // final high cycle
   endtask

   // one write; inject=1 fires a second start with other data mid-transfer
   task automatic run_write(input string tag, input logic [5:0] dv, input logic [1:0] kd,
                            input logic ex, input logic [7:0] a, input logic [7:0] b,
                            input bit inject);
      int ncap, mis_clk, mis_dat, mis_sel, first_bad, nedge, ebit;
      logic [23:0] got, want;
      int nbits;
      build_expected(dv, kd, ex, a, b);
      ncap = e_len + 24;
      @(negedge clk);
      dev_addr = dv; reg_kind = kd; ext_write = ex; byte_a = a; byte_b = b;
      start = 1'b1;
      for (int j = 0; j < ncap; j++) begin
         @(negedge clk);
         c_oe[j] = wire_oe; c_clk[j] = wire_clk; c_dat[j] = wire_dat;
         c_sel[j] = wire_sel; c_done[j] = done; c_busy[j] = busy;
         start = 1'b0;
         if (inject && j == 30) begin
            start = 1'b1;
            dev_addr = ~dv; reg_kind = ~kd; ext_write = ~ex; byte_a = ~a; byte_b = ~b;
         end
      end
      // R2: engage timing
      chk(!c_oe[0] && !c_busy[0], "R2", {tag, " idle one sample after start"},
          {c_oe[0], c_busy[0]}, 0);
      chk(c_oe[1] && c_busy[1], "R2", {tag, " lines driven on second sample"},
          {c_oe[1], c_busy[1]}, 3);
      // R4/R5/R7 clock, R3/R8 data, R6 select: cycle-exact comparison
      mis_clk = 0; mis_dat = 0; mis_sel = 0; first_bad = -1;
      for (int i = 0; i < e_len; i++) begin
         if (!c_oe[i+1] || c_clk[i+1] !== e_clk[i]) begin
            mis_clk++;
            if (first_bad < 0) first_bad = i;
         end
         if (c_dat[i+1] !== e_dat[i]) mis_dat++;
         if (c_sel[i+1] !== e_sel[i]) mis_sel++;
      end
      chk(mis_clk == 0, "R4/R5/R7", {tag, " clock waveform mismatches (first index)"},
          first_bad, -1);
      chk(mis_dat == 0, "R8", {tag, " data line mismatching cycles"}, mis_dat, 0);
      chk(mis_sel == 0, "R6", {tag, " select line mismatching cycles"}, mis_sel, 0);
      // R3: decode bits at rising clock, skip the halt rise before byte b
      nedge = 0; nbits = 0; got = '0;
      for (int i = 2; i <= e_len; i++) begin
         if (c_oe[i] && c_clk[i] && !c_clk[i-1]) begin
            ebit = nedge;
            nedge++;
            if (!(ex && ebit == 16)) begin
               if (nbits < 24) got[nbits] = c_dat[i];
               nbits++;
            end
         end
      end
      want = ex ? {b, a, dv, kd} : {8'h00, a, dv, kd};
      chk(nbits == (ex ? 24 : 16), "R3", {tag, " bit cells sent"}, nbits, ex ? 24 : 16);
      chk(got == want, "R3", {tag, " bytes decoded LSB first"}, int'(got), int'(want));
      // R9: release and done pulse
      chk(!c_oe[e_len+1] && c_done[e_len+1] && !c_busy[e_len+1], "R9",
          {tag, " release with done"}, {c_oe[e_len+1], c_done[e_len+1], c_busy[e_len+1]}, 2);
      chk(!c_done[e_len+2], "R9", {tag, " done lasts one cycle"}, c_done[e_len+2], 0);
      // R10 (and R9): nothing further after release
      mis_clk = 0;
      for (int j = e_len + 1; j < ncap; j++)
         if (c_oe[j] || c_busy[j]) mis_clk++;
      chk(mis_clk == 0, "R10", {tag, " lines stay released after done"}, mis_clk, 0);
      dev_addr = dv; reg_kind = kd; ext_write = ex; byte_a = a; byte_b = b;
   endtask

   task automatic t_reset_state();
      chk(!wire_oe && !busy && !done, "R1", "after power-on reset",
          {wire_oe, busy, done}, 0);
   endtask

   task automatic t_direct();
      run_write("direct", 6'h05, 2'b10, 1'b0, 8'hA5, 8'h00, 1'b0);
   endtask

   task automatic t_extended();
      run_write("extended", 6'h2A, 2'b00, 1'b1, 8'hC0, 8'h1E, 1'b0);
   endtask

   task automatic t_patterns();
      run_write("ones", 6'h3F, 2'b11, 1'b1, 8'hFF, 8'h00, 1'b0);
      run_write("zeros", 6'h00, 2'b00, 1'b0, 8'h00, 8'hFF, 1'b0);
   endtask

   task automatic t_busy_start();
      run_write("start-while-busy", 6'h11, 2'b01, 1'b1, 8'h3C, 8'h81, 1'b1);
   endtask

   task automatic t_reset_mid();
      @(negedge clk);
      dev_addr = 6'h12; reg_kind = 2'b01; ext_write = 1'b1; byte_a = 8'h55; byte_b = 8'hAA;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (40) @(negedge clk);
      chk(wire_oe, "R1", "transfer running before mid reset", wire_oe, 1);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk(!wire_oe && !busy && !done, "R1", "first sample after mid reset",
          {wire_oe, busy, done}, 0);
      repeat (5) @(negedge clk);
      chk(!wire_oe && !busy && !done, "R1", "still idle after mid reset",
          {wire_oe, busy, done}, 0);
      run_write("after-reset", 6'h09, 2'b11, 1'b0, 8'h96, 8'h00, 1'b0);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      t_reset_state();
      t_direct();
      t_extended();
      t_patterns();
      t_busy_start();
      t_reset_mid();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule